// File: doc/BRIEF.md
# Row Command Packet Decoder

This block sits behind the packet deframer of one banked DRAM device and turns each row-control packet into command strobes. A packet carries a device-select field, a bank number and, depending on an activate flag, either a row address or an 11-bit row-operation word. The device-select field is a true/false pair that encodes the top ID bit together with "packet present", plus four low ID bits. It is compared with a programmed 5-bit device ID, and the pair can also mark the packet as a broadcast to every device.

A matched packet with the activate flag set opens a row. Otherwise the operation word is decoded. Several commands may share one word: precharge, a power command and a relax/attention choice can all be asserted at once. The block keeps a 9-bit refresh row counter that supplies the row for refresh-activate, and a 2-bit power-state register. Strobes are registered single-cycle pulses. Any word outside the accepted forms raises an illegal flag instead of a command.

Top module: `rowpkt_decoder`

## Requirements
- R1: Device select: `sel_hi_t`=1,`sel_hi_f`=1 is a broadcast and always matches; `sel_hi_t`=0,`sel_hi_f`=1 matches when `dev_id` equals {0,`sel_lo`}; `sel_hi_t`=1,`sel_hi_f`=0 matches when `dev_id` equals {1,`sel_lo`}; both 0 never matches. An unmatched packet produces no strobe and leaves all state unchanged.
- R2: A matched packet with `is_act`=1 pulses `act_o`, presents `bank` and `row` on `bank_o`/`row_o`, and sets the power state to ATTN. The operation word is ignored.
- R3: With `is_act`=0, `pre_o` pulses for op[10:6]=11000 with op[2:0]=000 (op[5:3] free), and for op[10:4]=1010100 with op[2:0]=000 (op[3] free).
- R4: op[10:4]=0001100 with op[2:0]=000 pulses `refa_o` with `row_o` equal to the refresh counter value before the packet. The counter increments, wrapping 511 to 0, only when such a packet carries a bank number of all ones.
- R5: Power commands are decoded when op[8:6]=000, op[10:9] is 00 or 11, and op[2:0]=000. op[5:4]=01 pulses `pdn_o`, 10 pulses `nap_o`, and 11 pulses `napc_o`. The power state `pwr_o` is encoded ATTN=0, STBY=1, NAP=2, PDN=3. In priority order: activate gives ATTN, powerdown gives PDN, nap gives NAP, conditional nap gives NAP only from ATTN, relax gives STBY, and attention gives ATTN. The state changes only on a matched legal packet.
- R6: For any accepted word with op[2:0]=000, op[3]=1 pulses `rlx_o`, and op[3]=0 pulses `attn_o` unless the whole word is zero. An attention carried by a broadcast does not move the state out of STBY.
- R7: op[10:3]=0 with op[2:0]=001 pulses `cal_o`, and with 010 pulses `calen_o`. Neither changes the power state. An all-zero word raises no strobe.
- R8: A combined word such as 11000111000 pulses `pre_o`, `napc_o` and `rlx_o` in the same cycle.
- R9: A matched non-activate packet whose word fits none of the forms above pulses `illegal_o`. No other strobe is raised, and the power state, refresh counter, `bank_o` and `row_o` stay unchanged.
- R10: Strobes appear in the cycle after the clock edge that samples `pkt_valid` and last exactly one cycle. After reset all strobes are 0, `pwr_o` is STBY (1) and `refrow_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dev_id | input | 5 | Programmed device ID |
| pkt_valid | input | 1 | Packet fields valid this cycle |
| sel_hi_t | input | 1 | Device-select true half of top ID bit |
| sel_hi_f | input | 1 | Device-select false half of top ID bit |
| sel_lo | input | 4 | Device-select low ID bits |
| is_act | input | 1 | Packet is a row activate |
| bank | input | BANK_W (5) | Bank number |
| row | input | ROW_W (9) | Row address for activate |
| op | input | 11 | Row-operation word |
| act_o | output | 1 | Activate strobe |
| pre_o | output | 1 | Precharge strobe |
| refa_o | output | 1 | Refresh-activate strobe |
| cal_o | output | 1 | Temperature calibrate strobe |
| calen_o | output | 1 | Calibrate-and-enable strobe |
| pdn_o | output | 1 | Powerdown command strobe |
| nap_o | output | 1 | Nap command strobe |
| napc_o | output | 1 | Conditional nap command strobe |
| rlx_o | output | 1 | Relax command strobe |
| attn_o | output | 1 | Attention command strobe |
| illegal_o | output | 1 | Unaccepted operation word |
| bank_o | output | BANK_W (5) | Bank for the current strobe |
| row_o | output | ROW_W (9) | Row for the current strobe |
| pwr_o | output | 2 | Power state |
| refrow_o | output | ROW_W (9) | Refresh row counter |

## Verification
Every result is due one clock after the edge that samples the packet. The strobes, `bank_o`/`row_o`, the power state and the refresh counter are all registered at that same edge. The bench therefore drives a packet at a falling edge, drops `pkt_valid` at the next falling edge, and reads every output at that moment, half a cycle after the capturing edge. The sweep of all 2048 operation words is run from both ATTN and STBY and for both a matched and a broadcast packet, so the power-state predictions always start from a known state. The refresh test reads the counter through `row_o` on each refresh-activate, and each read comes one cycle after the packet that produced it.

// File: rtl/rowpkt_pkg.sv
package rowpkt_pkg;

  localparam int unsigned ID_W = 5;
  localparam int unsigned OP_W = 11;

  typedef enum logic [1:0] {
    PWR_ATTN = 2'd0,
    PWR_STBY = 2'd1,
    PWR_NAP  = 2'd2,
    PWR_PDN  = 2'd3
  } pwr_e;

  typedef struct packed {
    logic act;
    logic pre;
    logic refa;
    logic cal;
    logic calen;
    logic pdn;
    logic nap;
    logic napc;
    logic rlx;
    logic attn;
    logic illegal;
  } cmd_t;

endpackage

// File: rtl/rowpkt_devmatch.sv
module rowpkt_devmatch
  import rowpkt_pkg::*;
(
  input  logic [ID_W-1:0] dev_id,
  input  logic            sel_hi_t,
  input  logic            sel_hi_f,
  input  logic [ID_W-2:0] sel_lo,
  output logic            hit,
  output logic            bcast
);

  always_comb begin
    hit   = 1'b0;
    bcast = 1'b0;
    unique case ({sel_hi_t, sel_hi_f})
      2'b11: begin
        hit   = 1'b1;
        bcast = 1'b1;
      end
      2'b01:   hit = (dev_id == {1'b0, sel_lo});
      2'b10:   hit = (dev_id == {1'b1, sel_lo});
      default: hit = 1'b0;
    endcase
  end

endmodule

// File: rtl/rowpkt_opdec.sv
module rowpkt_opdec
  import rowpkt_pkg::*;
(
  input  logic            is_act,
  input  logic [OP_W-1:0] op,
  output cmd_t            cmd
);

  logic low_zero;
  logic f_pre, f_refp, f_refa, f_pwr, f_cal, f_calen, f_zero, legal;

  always_comb begin
    low_zero = (op[2:0] == 3'b000);
    f_pre    = low_zero && (op[10:6] == 5'b11000);
    f_refp   = low_zero && (op[10:4] == 7'b1010100);
    f_refa   = low_zero && (op[10:4] == 7'b0001100);
    f_pwr    = low_zero && (op[8:6] == 3'b000) &&
               ((op[10:9] == 2'b00) || (op[10:9] == 2'b11));
    f_cal    = (op[10:3] == 8'd0) && (op[2:0] == 3'b001);
    f_calen  = (op[10:3] == 8'd0) && (op[2:0] == 3'b010);
    f_zero   = (op == '0);
    legal    = f_pre | f_refp | f_refa | f_pwr | f_cal | f_calen;

    cmd = '0;
    if (is_act) begin
      cmd.act = 1'b1;
    end else if (!legal) begin
      cmd.illegal = 1'b1;
    end else begin
      cmd.pre   = f_pre | f_refp;
      cmd.refa  = f_refa;
      cmd.cal   = f_cal;
      cmd.calen = f_calen;
      cmd.pdn   = f_pwr && (op[5:4] == 2'b01);
      cmd.nap   = f_pwr && (op[5:4] == 2'b10);
      cmd.napc  = f_pwr && (op[5:4] == 2'b11);
      cmd.rlx   = low_zero && op[3];
      cmd.attn  = low_zero && !op[3] && !f_zero;
    end
  end

endmodule

// File: rtl/rowpkt_pwrfsm.sv
module rowpkt_pwrfsm
  import rowpkt_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  cmd_t cmd,
  input  logic bcast,
  output pwr_e state
);

  pwr_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    if (en) begin
      if (cmd.act)                                state_d = PWR_ATTN;
      else if (cmd.pdn)                           state_d = PWR_PDN;
      else if (cmd.nap)                           state_d = PWR_NAP;
      else if (cmd.napc && state_q == PWR_ATTN)   state_d = PWR_NAP;
      else if (cmd.rlx)                           state_d = PWR_STBY;
      else if (cmd.attn && !(bcast && state_q == PWR_STBY))
                                                  state_d = PWR_ATTN;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  state_q <= PWR_STBY;
    else if (en) state_q <= state_d;
  end

  assign state = state_q;

endmodule

// File: rtl/rowpkt_refctr.sv
module rowpkt_refctr #(
  parameter int unsigned ROW_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bump,
  output logic [ROW_W-1:0] count
);

  logic [ROW_W-1:0] cnt_q, cnt_d;

  always_comb cnt_d = cnt_q + {{(ROW_W-1){1'b0}}, 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt_q <= '0;
    else if (bump) cnt_q <= cnt_d;
  end

  assign count = cnt_q;

endmodule

// File: rtl/rowpkt_decoder.sv
module rowpkt_decoder
  import rowpkt_pkg::*;
#(
  parameter int unsigned BANK_W = 5,
  parameter int unsigned ROW_W  = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [4:0]        dev_id,
  input  logic              pkt_valid,
  input  logic              sel_hi_t,
  input  logic              sel_hi_f,
  input  logic [3:0]        sel_lo,
  input  logic              is_act,
  input  logic [BANK_W-1:0] bank,
  input  logic [ROW_W-1:0]  row,
  input  logic [10:0]       op,
  output logic              act_o,
  output logic              pre_o,
  output logic              refa_o,
  output logic              cal_o,
  output logic              calen_o,
  output logic              pdn_o,
  output logic              nap_o,
  output logic              napc_o,
  output logic              rlx_o,
  output logic              attn_o,
  output logic              illegal_o,
  output logic [BANK_W-1:0] bank_o,
  output logic [ROW_W-1:0]  row_o,
  output logic [1:0]        pwr_o,
  output logic [ROW_W-1:0]  refrow_o
);

  localparam logic [BANK_W-1:0] BANK_TOP = {BANK_W{1'b1}};

  logic             hit, bcast, take, take_ok, bump;
  cmd_t             cmd, strb_q, strb_d;
  pwr_e             pwr_state;
  logic [ROW_W-1:0] ref_row, row_d;

  rowpkt_devmatch u_match (
    .dev_id   (dev_id),
    .sel_hi_t (sel_hi_t),
    .sel_hi_f (sel_hi_f),
    .sel_lo   (sel_lo),
    .hit      (hit),
    .bcast    (bcast)
  );

  rowpkt_opdec u_dec (
    .is_act (is_act),
    .op     (op),
    .cmd    (cmd)
  );

  always_comb begin
    take    = pkt_valid && hit;
    take_ok = take && !cmd.illegal;
    bump    = take_ok && cmd.refa && (bank == BANK_TOP);
    strb_d  = take ? cmd : '0;
    row_d   = cmd.refa ? ref_row : row;
  end

  rowpkt_pwrfsm u_pwr (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (take_ok),
    .cmd   (cmd),
    .bcast (bcast),
    .state (pwr_state)
  );

  rowpkt_refctr #(.ROW_W(ROW_W)) u_ref (
    .clk   (clk),
    .rst_n (rst_n),
    .bump  (bump),
    .count (ref_row)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) strb_q <= '0;
    else        strb_q <= strb_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bank_o <= '0;
      row_o  <= '0;
    end else if (take_ok) begin
      bank_o <= bank;
      row_o  <= row_d;
    end
  end

  assign act_o     = strb_q.act;
  assign pre_o     = strb_q.pre;
  assign refa_o    = strb_q.refa;
  assign cal_o     = strb_q.cal;
  assign calen_o   = strb_q.calen;
  assign pdn_o     = strb_q.pdn;
  assign nap_o     = strb_q.nap;
  assign napc_o    = strb_q.napc;
  assign rlx_o     = strb_q.rlx;
  assign attn_o    = strb_q.attn;
  assign illegal_o = strb_q.illegal;
  assign pwr_o     = pwr_state;
  assign refrow_o  = ref_row;

endmodule

// File: rtl/rowpkt_decoder_chk.sv
module rowpkt_decoder_chk #(
  parameter int unsigned BANK_W = 5,
  parameter int unsigned ROW_W  = 9
) (
  input logic              clk,
  input logic              rst_n,
  input logic              pkt_valid,
  input logic              sel_hi_t,
  input logic              sel_hi_f,
  input logic              act_o,
  input logic              pre_o,
  input logic              refa_o,
  input logic              cal_o,
  input logic              calen_o,
  input logic              pdn_o,
  input logic              nap_o,
  input logic              napc_o,
  input logic              rlx_o,
  input logic              attn_o,
  input logic              illegal_o,
  input logic [BANK_W-1:0] bank_o,
  input logic [1:0]        pwr_o,
  input logic [ROW_W-1:0]  refrow_o
);

  logic any_cmd;
  assign any_cmd = act_o | pre_o | refa_o | cal_o | calen_o | pdn_o |
                   nap_o | napc_o | rlx_o | attn_o;

  AST_NO_PACKET_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    $past(pkt_valid && !sel_hi_t && !sel_hi_f) |-> !(any_cmd || illegal_o)); // R1

  AST_ACT_ATTN: assert property (@(posedge clk) disable iff (!rst_n)
    act_o |-> (pwr_o == 2'd0)); // R2

  AST_REFROW_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (refrow_o != $past(refrow_o)) |->
      (refa_o && (&bank_o) && (refrow_o == $past(refrow_o) + 1'b1))); // R4

  AST_PWR_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(pkt_valid) |-> $stable(pwr_o)); // R5

  AST_ILLEGAL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_o |-> !any_cmd); // R9

  AST_STROBE_AFTER_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    (any_cmd || illegal_o) |-> $past(pkt_valid)); // R10

endmodule

bind rowpkt_decoder rowpkt_decoder_chk #(.BANK_W(BANK_W), .ROW_W(ROW_W)) u_chk (.*);

// File: tb/rowpkt_decoder_test.sv
module rowpkt_decoder_test;

  logic        clk;
  logic        rst_n;
  logic [4:0]  dev_id;
  logic        pkt_valid, sel_hi_t, sel_hi_f, is_act;
  logic [3:0]  sel_lo;
  logic [4:0]  bank;
  logic [8:0]  row;
  logic [10:0] op;
  logic        act_o, pre_o, refa_o, cal_o, calen_o, pdn_o, nap_o, napc_o;
  logic        rlx_o, attn_o, illegal_o;
  logic [4:0]  bank_o;
  logic [8:0]  row_o;
  logic [1:0]  pwr_o;
  logic [8:0]  refrow_o;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  rowpkt_decoder uut (.*);

  initial clk = 1'b0;
  always #2 clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 190000) begin
      errors = errors + 1;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks + 1, errors);
      $finish;
    end
  end

  function automatic logic [10:0] outs();
    return {act_o, pre_o, refa_o, cal_o, calen_o, pdn_o, nap_o, napc_o,
            rlx_o, attn_o, illegal_o};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Drive one packet at a falling edge; outputs are read one edge later.
  task automatic send(input logic t, input logic f, input logic [3:0] lo,
                      input logic a, input logic [10:0] o, input logic [4:0] b);
    sel_hi_t = t; sel_hi_f = f; sel_lo = lo; is_act = a; op = o; bank = b;
    pkt_valid = 1'b1;
    @(negedge clk);
    pkt_valid = 1'b0;
  endtask

  // Expected strobes {act,pre,refa,cal,calen,pdn,nap,napc,rlx,attn,illegal}
  // and next power state from the requirement encodings (R3..R9).
  function automatic logic [12:0] model(input logic [10:0] o, input logic bc,
                                        input logic [1:0] st);
    logic lz, p, rp, ra, pw, c1, c2, ok;
    logic [10:0] v;
    logic [1:0] ns;
    lz = (o % 8) == 0;
    p  = lz && (o / 64) == 24;
    rp = lz && (o / 16) == 84;
    ra = lz && (o / 16) == 12;
    pw = lz && ((o / 64) % 8) == 0 && ((o / 512) == 0 || (o / 512) == 3);
    c1 = o == 1;
    c2 = o == 2;
    ok = p | rp | ra | pw | c1 | c2;
    v = 0; ns = st;
    if (!ok) v[0] = 1'b1;
    else begin
      v[9] = p | rp;  v[8] = ra;  v[7] = c1;  v[6] = c2;
      v[5] = pw && ((o / 16) % 4) == 1;
      v[4] = pw && ((o / 16) % 4) == 2;
      v[3] = pw && ((o / 16) % 4) == 3;
      v[2] = lz && o[3];
      v[1] = lz && !o[3] && o != 0;
      if (v[5]) ns = 2'd3;
      else if (v[4]) ns = 2'd2;
      else if (v[3] && st == 2'd0) ns = 2'd2;
      else if (v[2]) ns = 2'd1;
      else if (v[1] && !(bc && st == 2'd1)) ns = 2'd0;
    end
    return {ns, v};
  endfunction

  initial begin
    rst_n = 1'b0; pkt_valid = 0; sel_hi_t = 0; sel_hi_f = 0; sel_lo = 0;
    is_act = 0; bank = 0; row = 9'h0AB; op = 0; dev_id = 5'd19;
    repeat (3) @(negedge clk);
    // R10: reset state
    chk("R10 reset strobes", outs(), 0);
    chk("R10 reset pwr STBY", pwr_o, 2'd1);
    chk("R10 reset refrow", refrow_o, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: device match sweep using activate packets
    foreach (dev_id[k]) ; // no-op keeps dev_id referenced
    for (int idsel = 0; idsel < 4; idsel++) begin
      logic [4:0] idv;
      idv = (idsel == 0) ? 5'd0 : (idsel == 1) ? 5'd5 : (idsel == 2) ? 5'd16 : 5'd31;
      dev_id = idv;
      for (int tf = 0; tf < 4; tf++) begin
        for (int lo = 0; lo < 16; lo++) begin
          logic expm;
          expm = (tf == 3) || (tf == 1 && idv == lo) || (tf == 2 && idv == 16 + lo);
          send(tf[1], tf[0], lo[3:0], 1'b1, 11'd0, 5'd7);
          chk("R1 match", act_o, expm);
          if (tf == 0) chk("R1 no packet quiet", outs(), 0);
        end
      end
    end
    dev_id = 5'd19;

    // R2: activate presents bank/row and moves to ATTN
    send(1, 0, 4'd3, 1'b0, 11'b00000001000, 5'd0);      // relax -> STBY
    row = 9'h155;
    send(1, 0, 4'd3, 1'b1, 11'b11111111111, 5'd22);
    chk("R2 act strobe", outs(), 11'b10000000000);
    chk("R2 bank", bank_o, 5'd22);
    chk("R2 row", row_o, 9'h155);
    chk("R2 pwr ATTN", pwr_o, 2'd0);
    @(negedge clk);
    chk("R10 single-cycle pulse", act_o, 0);
    row = 9'h0AB;

    // R3..R9: every operation word, from ATTN and STBY, matched and broadcast
    for (int bc = 0; bc < 2; bc++) begin
      for (int st = 0; st < 2; st++) begin
        for (int o = 0; o < 2048; o++) begin
          logic [12:0] m;
          logic [1:0]  pre_st;
          if (st == 0) send(1, 0, 4'd3, 1'b1, 11'd0, 5'd3);
          else         send(1, 0, 4'd3, 1'b0, 11'b00000001000, 5'd3);
          pre_st = st[0] ? 2'd1 : 2'd0;
          if (bc == 1) send(1, 1, 4'd0, 1'b0, o[10:0], 5'd3);
          else         send(1, 0, 4'd3, 1'b0, o[10:0], 5'd3);
          m = model(o[10:0], bc[0], pre_st);
          chk("R3 R5 R6 R7 R9 strobes", outs(), m[10:0]);
          chk("R5 R6 R9 pwr", pwr_o, m[12:11]);
          if (m[8]) chk("R4 refa row from counter", row_o, 0);
          if (m[0]) chk("R9 row held", row_o, 9'h0AB);
        end
      end
    end

    // R6: broadcast attention from STBY keeps STBY
    send(1, 0, 4'd3, 1'b0, 11'b00000001000, 5'd3);
    send(1, 1, 4'd9, 1'b0, 11'b11000000000, 5'd3);
    chk("R6 bcast attn strobes", outs(), 11'b01000000010);
    chk("R6 bcast attn stays STBY", pwr_o, 2'd1);

    // R8: combined precharge + conditional nap + relax, from ATTN
    send(1, 0, 4'd3, 1'b1, 11'd0, 5'd3);
    send(1, 0, 4'd3, 1'b0, 11'b11000111000, 5'd4);
    chk("R8 combined strobes", outs(), 11'b01000001100);
    chk("R8 combined pwr NAP", pwr_o, 2'd2);

    // R4: refresh with non-top bank does not advance
    send(1, 0, 4'd3, 1'b0, 11'b00011000000, 5'd30);
    chk("R4 no bump row", row_o, 0);
    chk("R4 no bump counter", refrow_o, 0);
    // R4: refresh with top bank walks 0..511 then wraps
    for (int i = 0; i < 513; i++) begin
      send(1, 0, 4'd3, 1'b0, 11'b00011000000, 5'd31);
      chk("R4 refa row", row_o, i % 512);
      chk("R4 refa strobe", refa_o, 1);
    end
    chk("R4 wrapped counter", refrow_o, 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule